// File: doc/BRIEF.md
# Direction-Aware Timer Output Stage

This block keeps the levels of seven timer output pins in registers and updates them each clock from per-output set, clear and toggle requests. Those requests come from event logic outside the block. Each output also has a two-bit direction selector. The selector can make set and clear trade places while a chosen counter counts down. A centre-aligned pulse can then use the same match event to raise the pin on the way up and lower it on the way down.

Software has two registers. The pin register can be read at any time. A write to it forces the pins, but only when every counter is stopped. The direction selector register can be written and read at any time. The counters, their direction logic and the event matching sit outside the block. Their halt and down-count flags, and a flag that joins the two halves into one unified counter, come in as inputs.

Top module: `pwm_out_dirctl`

## Requirements
- R1: After reset every pin reads 0 on `pins_q` and every direction selector field reads 0 on `mode_q`.
- R2: When the counters count as halted, `pins_wr_en` loads `pins_wdata` bit n into pin n on the next edge. This write takes priority over any request made in the same cycle.
- R3: The counters count as halted when `halt_lo` is 1 and either `unify` or `halt_hi` is 1. At any other time a pin write is ignored and the pins keep their levels.
- R4: A set request drives the pin to 1 and a clear request drives it to 0, on the next edge. Set and clear together, after any swap, invert the pin. A toggle request alone inverts the pin. Set or clear takes priority over toggle. With no request, the pin holds.
- R5: Selector code 0 (and the reserved code 3) leaves set and clear unswapped whatever the direction flags are.
- R6: Selector code 1 swaps set and clear while `dn_lo` is 1. `dn_lo` stands for the low half or for the unified counter.
- R7: Selector code 2 swaps set and clear while `dn_hi` is 1 and `unify` is 0. While `unify` is 1, code 2 behaves as code 0.
- R8: Toggle requests are never changed by any selector code or direction flag.
- R9: The selector for output k sits in `mode_q` bits 2k+1:2k. `mode_wr_en` loads `mode_wdata` on the next edge whether or not the counters are halted.
- R10: `pins_q` always presents the current pin levels, including while counters run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pins_wr_en | input | 1 | Software write strobe for pin register |
| pins_wdata | input | 7 | Pin levels to force |
| mode_wr_en | input | 1 | Software write strobe for selector register |
| mode_wdata | input | 14 | Direction selector fields |
| halt_lo | input | 1 | Low half or unified counter halted |
| halt_hi | input | 1 | High half counter halted |
| dn_lo | input | 1 | Low half or unified counter counting down |
| dn_hi | input | 1 | High half counter counting down |
| unify | input | 1 | Counter halves joined into one |
| set_req | input | 7 | Per-output set requests |
| clr_req | input | 7 | Per-output clear requests |
| tog_req | input | 7 | Per-output toggle requests |
| pins_q | output | 7 | Current pin levels (readback) |
| mode_q | output | 14 | Current selector fields (readback) |

## Verification
The bench applies a halt state that is only partly halted. A design that required only the low flag, or both flags, would then take or drop a write in the unified case. Code 2 is exercised with `unify` both 0 and 1. A design that ignored the unify gate would invert clears into sets. Outputs are given mixed selector codes, so that a selector decoded at the wrong field offset lands on the wrong pin. Set together with clear is checked to invert the pin, and set together with toggle is checked to let set win, which catches a wrong priority order.

// File: rtl/owc_pkg.sv
package owc_pkg;
    parameter int NUM_OUT = 7;
    localparam int FLD_W  = 2;
    localparam int MODE_W = NUM_OUT * FLD_W;

    typedef enum logic [FLD_W-1:0] {
        DIR_NONE = 2'd0,
        DIR_LO   = 2'd1,
        DIR_HI   = 2'd2,
        DIR_RSVD = 2'd3
    } dir_sel_e;

    typedef struct packed {
        logic [NUM_OUT-1:0] pins;
        logic [MODE_W-1:0]  mode;
    } owc_state_t;
endpackage

// File: rtl/owc_swap.sv
module owc_swap
    import owc_pkg::*;
#(
    parameter int N  = NUM_OUT,
    parameter int FW = FLD_W
) (
    input  logic [N*FW-1:0] mode,
    input  logic            dn_lo,
    input  logic            dn_hi,
    input  logic            unify,
    input  logic [N-1:0]    set_req,
    input  logic [N-1:0]    clr_req,
    output logic [N-1:0]    eff_set,
    output logic [N-1:0]    eff_clr
);
    for (genvar k = 0; k < N; k++) begin : g_out
        dir_sel_e code_k;
        logic     swap_k;
        assign code_k  = dir_sel_e'(mode[k*FW +: FW]);
        assign swap_k  = ((code_k == DIR_LO) && dn_lo)
                       || ((code_k == DIR_HI) && !unify && dn_hi);
        assign eff_set[k] = swap_k ? clr_req[k] : set_req[k];
        assign eff_clr[k] = swap_k ? set_req[k] : clr_req[k];
    end
endmodule

// File: rtl/owc_apply.sv
module owc_apply
    import owc_pkg::*;
#(
    parameter int N = NUM_OUT
) (
    input  logic [N-1:0] cur,
    input  logic [N-1:0] eff_set,
    input  logic [N-1:0] eff_clr,
    input  logic [N-1:0] tog_req,
    output logic [N-1:0] nxt
);
    always_comb begin
        for (int k = 0; k < N; k++) begin
            if (eff_set[k] && eff_clr[k])
                nxt[k] = ~cur[k];
            else if (eff_set[k])
                nxt[k] = 1'b1;
            else if (eff_clr[k])
                nxt[k] = 1'b0;
            else if (tog_req[k])
                nxt[k] = ~cur[k];
            else
                nxt[k] = cur[k];
        end
    end
endmodule

// File: rtl/pwm_out_dirctl.sv
module pwm_out_dirctl
    import owc_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pins_wr_en,
    input  logic [NUM_OUT-1:0] pins_wdata,
    input  logic               mode_wr_en,
    input  logic [MODE_W-1:0]  mode_wdata,
    input  logic               halt_lo,
    input  logic               halt_hi,
    input  logic               dn_lo,
    input  logic               dn_hi,
    input  logic               unify,
    input  logic [NUM_OUT-1:0] set_req,
    input  logic [NUM_OUT-1:0] clr_req,
    input  logic [NUM_OUT-1:0] tog_req,
    output logic [NUM_OUT-1:0] pins_q,
    output logic [MODE_W-1:0]  mode_q
);
    owc_state_t         st_d, st_q;
    logic [NUM_OUT-1:0] eff_set, eff_clr, evt_pins;
    logic               all_halted;

    owc_swap #(.N(NUM_OUT), .FW(FLD_W)) u_swap (
        .mode    (st_q.mode),
        .dn_lo   (dn_lo),
        .dn_hi   (dn_hi),
        .unify   (unify),
        .set_req (set_req),
        .clr_req (clr_req),
        .eff_set (eff_set),
        .eff_clr (eff_clr)
    );

    owc_apply #(.N(NUM_OUT)) u_apply (
        .cur     (st_q.pins),
        .eff_set (eff_set),
        .eff_clr (eff_clr),
        .tog_req (tog_req),
        .nxt     (evt_pins)
    );

    always_comb begin
        st_d       = st_q;
        all_halted = halt_lo && (unify || halt_hi);
        if (mode_wr_en)
            st_d.mode = mode_wdata;
        if (pins_wr_en && all_halted)
            st_d.pins = pins_wdata;
        else
            st_d.pins = evt_pins;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign pins_q = st_q.pins;
    assign mode_q = st_q.mode;

    // R3: a write while any counter runs, with no requests, leaves pins alone
    a_r3_write_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (pins_wr_en && !halt_lo && set_req == '0 && clr_req == '0 && tog_req == '0)
        |=> $stable(pins_q));

    // R2: a halted write lands on the next edge
    a_r2_halted_write: assert property (@(posedge clk) disable iff (!rst_n)
        (pins_wr_en && halt_lo && halt_hi) |=> (pins_q == $past(pins_wdata)));

    // R9: selector write accepted at any time
    a_r9_mode_load: assert property (@(posedge clk) disable iff (!rst_n)
        mode_wr_en |=> (mode_q == $past(mode_wdata)));

    // R4: with no request and no write, every pin holds
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!pins_wr_en && set_req == '0 && clr_req == '0 && tog_req == '0)
        |=> $stable(pins_q));

    // R8: toggle-only requests invert exactly the requested pins
    a_r8_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (!pins_wr_en && set_req == '0 && clr_req == '0)
        |=> (pins_q == ($past(pins_q) ^ $past(tog_req))));

    // R9: selector holds when not written
    a_r9_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_wr_en |=> $stable(mode_q));
endmodule

// File: tb/tb_pwm_out_dirctl.sv
module tb_pwm_out_dirctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pins_wr_en = 1'b0;
    logic [6:0]  pins_wdata = '0;
    logic        mode_wr_en = 1'b0;
    logic [13:0] mode_wdata = '0;
    logic        halt_lo = 1'b1, halt_hi = 1'b1;
    logic        dn_lo = 1'b0, dn_hi = 1'b0, unify = 1'b0;
    logic [6:0]  set_req = '0, clr_req = '0, tog_req = '0;
    logic [6:0]  pins_q;
    logic [13:0] mode_q;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    pwm_out_dirctl dut (
        .clk(clk), .rst_n(rst_n),
        .pins_wr_en(pins_wr_en), .pins_wdata(pins_wdata),
        .mode_wr_en(mode_wr_en), .mode_wdata(mode_wdata),
        .halt_lo(halt_lo), .halt_hi(halt_hi),
        .dn_lo(dn_lo), .dn_hi(dn_hi), .unify(unify),
        .set_req(set_req), .clr_req(clr_req), .tog_req(tog_req),
        .pins_q(pins_q), .mode_q(mode_q)
    );

    typedef struct packed {
        logic [6:0]  init;
        logic [13:0] mode;
        logic        dnl;
        logic        dnh;
        logic        uni;
        logic [6:0]  set;
        logic [6:0]  clr;
        logic [6:0]  tog;
        logic [6:0]  exp;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{7'h00, 14'h0000, 1'b0, 1'b0, 1'b0, 7'h03, 7'h0C, 7'h30, 7'h33},
        '{7'h7F, 14'h1555, 1'b1, 1'b0, 1'b0, 7'h0F, 7'h00, 7'h00, 7'h70},
        '{7'h00, 14'h1555, 1'b0, 1'b0, 1'b0, 7'h0F, 7'h00, 7'h00, 7'h0F},
        '{7'h00, 14'h2AAA, 1'b0, 1'b1, 1'b0, 7'h00, 7'h55, 7'h00, 7'h55},
        '{7'h00, 14'h2AAA, 1'b0, 1'b1, 1'b1, 7'h00, 7'h55, 7'h00, 7'h00},
        '{7'h00, 14'h3FFF, 1'b1, 1'b1, 1'b0, 7'h7F, 7'h00, 7'h00, 7'h7F},
        '{7'h0F, 14'h0000, 1'b0, 1'b0, 1'b0, 7'h03, 7'h03, 7'h00, 7'h0C},
        '{7'h2A, 14'h1555, 1'b1, 1'b0, 1'b0, 7'h00, 7'h00, 7'h7F, 7'h55},
        '{7'h00, 14'h0009, 1'b1, 1'b0, 1'b0, 7'h07, 7'h00, 7'h00, 7'h06},
        '{7'h00, 14'h0009, 1'b0, 1'b1, 1'b0, 7'h07, 7'h00, 7'h00, 7'h05}
    };

    function automatic string vec_tag(int i);
        case (i)
            0: return "R4 R5 plain set/clear/toggle";
            1: return "R6 code1 swap low down";
            2: return "R6 code1 no swap low up";
            3: return "R7 code2 swap high down";
            4: return "R7 code2 unified acts as code0";
            5: return "R5 code3 reserved no swap";
            6: return "R4 set+clear inverts";
            7: return "R8 toggle ignores direction";
            8: return "R9 field offsets low down";
            default: return "R9 field offsets high down";
        endcase
    endfunction

    task automatic check(string tag, logic [13:0] act, logic [13:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic halted_write(logic [6:0] v);
        @(negedge clk);
        halt_lo = 1'b1; halt_hi = 1'b1; unify = 1'b0;
        pins_wr_en = 1'b1; pins_wdata = v;
        @(negedge clk);
        pins_wr_en = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset values
        check("R1 pins after reset", {7'h0, pins_q}, 14'h0);
        check("R1 mode after reset", mode_q, 14'h0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            halt_lo = 1'b1; halt_hi = 1'b1; unify = 1'b0;
            pins_wr_en = 1'b1; pins_wdata = VECS[i].init;
            mode_wr_en = 1'b1; mode_wdata = VECS[i].mode;
            @(negedge clk);
            pins_wr_en = 1'b0; mode_wr_en = 1'b0;
            halt_lo = 1'b0; halt_hi = 1'b0;
            dn_lo = VECS[i].dnl; dn_hi = VECS[i].dnh; unify = VECS[i].uni;
            set_req = VECS[i].set; clr_req = VECS[i].clr; tog_req = VECS[i].tog;
            @(negedge clk);
            set_req = '0; clr_req = '0; tog_req = '0;
            dn_lo = 1'b0; dn_hi = 1'b0; unify = 1'b0;
            check(vec_tag(i), {7'h0, pins_q}, {7'h0, VECS[i].exp});
        end

        // R3: low halted only, split mode -> write ignored
        halted_write(7'h00);
        halt_lo = 1'b1; halt_hi = 1'b0; unify = 1'b0;
        pins_wr_en = 1'b1; pins_wdata = 7'h7F;
        @(negedge clk);
        pins_wr_en = 1'b0;
        check("R3 write ignored high running", {7'h0, pins_q}, 14'h0);

        // R3: unified and low halted -> write taken
        halt_lo = 1'b1; halt_hi = 1'b0; unify = 1'b1;
        pins_wr_en = 1'b1; pins_wdata = 7'h7F;
        @(negedge clk);
        pins_wr_en = 1'b0;
        check("R3 write taken unified halted", {7'h0, pins_q}, 14'h007F);

        // R3: low running -> ignored; R10 readback while running
        halt_lo = 1'b0; halt_hi = 1'b1; unify = 1'b0;
        pins_wr_en = 1'b1; pins_wdata = 7'h00;
        @(negedge clk);
        pins_wr_en = 1'b0;
        check("R3 R10 write ignored low running", {7'h0, pins_q}, 14'h007F);

        // R2: halted write beats same-cycle requests
        @(negedge clk);
        halt_lo = 1'b1; halt_hi = 1'b1;
        pins_wr_en = 1'b1; pins_wdata = 7'h11; clr_req = 7'h7F; tog_req = 7'h7F;
        @(negedge clk);
        pins_wr_en = 1'b0; clr_req = '0; tog_req = '0;
        check("R2 write priority over requests", {7'h0, pins_q}, 14'h0011);

        // R4: set beats toggle; toggle alone inverts
        halted_write(7'h00);
        halt_lo = 1'b0; halt_hi = 1'b0;
        mode_wr_en = 1'b1; mode_wdata = 14'h0;
        @(negedge clk);
        mode_wr_en = 1'b0;
        set_req = 7'h01; tog_req = 7'h03;
        @(negedge clk);
        set_req = '0; tog_req = '0;
        check("R4 set over toggle", {7'h0, pins_q}, 14'h0003);

        // R9: selector written while running
        mode_wr_en = 1'b1; mode_wdata = 14'h1B2C;
        @(negedge clk);
        mode_wr_en = 1'b0;
        check("R9 mode write while running", mode_q, 14'h1B2C);

        // R10: outputs hold and read back with no activity
        repeat (2) @(negedge clk);
        check("R10 readback stable", {7'h0, pins_q}, 14'h0003);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule